// File: doc/BRIEF.md
# Programmable Frequency Output Generator

This block derives a slower output frequency from its own clock. A down-counter is reloaded from a programmed value whenever it reaches zero. The resulting underflow events are offered in two forms. The first is a latch that inverts on every underflow, which gives a square wave with a 50% duty cycle. The second is the raw underflow strobe, which is one clock wide.

A single output pin is shared among three sources with a fixed priority. The clock itself has the highest priority, then the generated frequency, then a general-purpose data value. A side output reports which source currently drives the pin. Software programs the block through a one-cycle write port that loads every control field at once.

Top module: `fout_gen`

## Requirements
- R1: While and after reset, every control field is zero, `pin_src` reads 0 (general I/O) and `pin_out` equals `gpio_in`.
- R2: A write with `cfg_we` high loads all control fields at a rising edge and takes effect from that edge on. Field values presented while `cfg_we` is low change nothing.
- R3: While the frequency output is enabled, the counter decrements once per clock. On the cycle it reads zero it underflows and reloads the programmed value, so underflows repeat every reload+1 clocks.
- R4: With `cfg_sel_cnt` = 0, the output is a latch that inverts on every underflow. It rises one clock after the enabling edge and stays at each level for reload+1 clocks.
- R5: With `cfg_sel_cnt` = 1, the output is high for exactly one clock per underflow. The first high clock is one clock after the enabling edge. A reload value of 0 keeps the output high continuously.
- R6: With the clock-enable field at 1, `pin_out` carries the clock and `pin_src` reads 2, whatever the frequency-enable field says.
- R7: With the clock-enable field at 0 and the frequency-enable field at 1, `pin_out` carries the generated frequency and `pin_src` reads 1. With both at 0, the pin carries `gpio_in` and `pin_src` reads 0.
- R8: Clearing the frequency-enable field clears the counter and the toggle latch. A later enable therefore starts with the output low and underflows on the next clock.
- R9: A reload value written while the counter runs is used from the next underflow on. The period already under way is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; also the clock routed to the pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_clk_en | input | 1 | Route the clock to the pin (highest priority) |
| cfg_fo_en | input | 1 | Enable the generated frequency and its counter |
| cfg_sel_cnt | input | 1 | 0: toggle latch output, 1: underflow strobe output |
| cfg_reload | input | CNT_W | Reload value for the down-counter |
| gpio_in | input | 1 | General-purpose value driven when no other source is chosen |
| pin_out | output | 1 | Shared pin value |
| pin_src | output | 2 | Pin source: 0 general I/O, 1 frequency, 2 clock |

## Verification
The bench uses the default 6-bit counter width. With that width it can reach the largest reload value of 63, and it runs that case in strobe mode through two full periods. The small reload values 0, 1, 3 and 5 keep the other periods short, so one run covers both output modes, the reload-0 edge case, a reload change in the middle of a period and a disable followed by a re-enable.

// File: rtl/fout_pkg.sv
package fout_pkg;
    typedef enum logic [1:0] {
        SRC_GPIO = 2'd0,
        SRC_FREQ = 2'd1,
        SRC_CLK  = 2'd2
    } pin_src_e;
endpackage

// File: rtl/fout_cfg_regs.sv
module fout_cfg_regs #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             clk_en_i,
    input  logic             fo_en_i,
    input  logic             sel_cnt_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             clk_en_q,
    output logic             fo_en_q,
    output logic             sel_cnt_q,
    output logic [CNT_W-1:0] reload_q
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             clk_en;
        logic             fo_en;
        logic             sel_cnt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.reload  = reload_i;
            cfg_d.clk_en  = clk_en_i;
            cfg_d.fo_en   = fo_en_i;
            cfg_d.sel_cnt = sel_cnt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign clk_en_q  = cfg_q.clk_en;
    assign fo_en_q   = cfg_q.fo_en;
    assign sel_cnt_q = cfg_q.sel_cnt;
    assign reload_q  = cfg_q.reload;
endmodule

// File: rtl/fout_divider.sv
module fout_divider #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sel_cnt,
    input  logic [CNT_W-1:0] reload,
    output logic             freq_o
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tog;
        logic             pulse;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (!enable) begin
            div_d = '0;
        end else if (div_q.cnt == CNT_ZERO) begin
            div_d.cnt   = reload;
            div_d.tog   = ~div_q.tog;
            div_d.pulse = 1'b1;
        end else begin
            div_d.cnt   = div_q.cnt - CNT_ONE;
            div_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign freq_o = sel_cnt ? div_q.pulse : div_q.tog;
endmodule

// File: rtl/fout_pin_mux.sv
module fout_pin_mux
    import fout_pkg::*;
(
    input  logic     clk,
    input  logic     clk_en,
    input  logic     fo_en,
    input  logic     freq,
    input  logic     gpio,
    output logic     pin_out,
    output pin_src_e pin_src
);
    always_comb begin
        if (clk_en) begin
            pin_src = SRC_CLK;
            pin_out = clk;
        end else if (fo_en) begin
            pin_src = SRC_FREQ;
            pin_out = freq;
        end else begin
            pin_src = SRC_GPIO;
            pin_out = gpio;
        end
    end
endmodule

// File: rtl/fout_gen.sv
module fout_gen
    import fout_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_clk_en,
    input  logic             cfg_fo_en,
    input  logic             cfg_sel_cnt,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic             gpio_in,
    output logic             pin_out,
    output logic [1:0]       pin_src
);
    logic             clk_en_q;
    logic             fo_en_q;
    logic             sel_cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             freq;
    pin_src_e         src_sel;

    fout_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .clk_en_i  (cfg_clk_en),
        .fo_en_i   (cfg_fo_en),
        .sel_cnt_i (cfg_sel_cnt),
        .reload_i  (cfg_reload),
        .clk_en_q  (clk_en_q),
        .fo_en_q   (fo_en_q),
        .sel_cnt_q (sel_cnt_q),
        .reload_q  (reload_q)
    );

    fout_divider #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (fo_en_q),
        .sel_cnt (sel_cnt_q),
        .reload  (reload_q),
        .freq_o  (freq)
    );

    fout_pin_mux u_mux (
        .clk     (clk),
        .clk_en  (clk_en_q),
        .fo_en   (fo_en_q),
        .freq    (freq),
        .gpio    (gpio_in),
        .pin_out (pin_out),
        .pin_src (src_sel)
    );

    assign pin_src = src_sel;
endmodule

// File: rtl/fout_gen_chk.sv
module fout_gen_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en_q,
    input logic             fo_en_q,
    input logic             sel_cnt_q,
    input logic [CNT_W-1:0] reload_q,
    input logic             freq,
    input logic             gpio_in,
    input logic             pin_out,
    input logic [1:0]       pin_src
);
    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fo_en_q && sel_cnt_q && reload_q != '0 && freq) |=> (!sel_cnt_q || !freq));

    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fo_en_q) |=> (!freq));

    // R6
    clk_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_q |-> (pin_src == 2'd2));

    // R7
    gpio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_q && !fo_en_q) |-> (pin_src == 2'd0 && pin_out == gpio_in));

    // R7
    freq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_q && fo_en_q) |-> (pin_src == 2'd1 && pin_out == freq));
endmodule

bind fout_gen fout_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_q  (clk_en_q),
    .fo_en_q   (fo_en_q),
    .sel_cnt_q (sel_cnt_q),
    .reload_q  (reload_q),
    .freq      (freq),
    .gpio_in   (gpio_in),
    .pin_out   (pin_out),
    .pin_src   (pin_src)
);

// File: tb/test_fout_gen.sv
`timescale 1ns/1ps
module test_fout_gen;
    localparam int CNT_W = 6;

    // each entry: {reload, sel_cnt}
    localparam logic [CNT_W:0] VEC [0:6] = '{
        {6'd0,  1'b0}, {6'd0, 1'b1}, {6'd3, 1'b0}, {6'd3, 1'b1},
        {6'd5,  1'b1}, {6'd1, 1'b0}, {6'd63, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_clk_en = 1'b0;
    logic             cfg_fo_en = 1'b0;
    logic             cfg_sel_cnt = 1'b0;
    logic [CNT_W-1:0] cfg_reload = '0;
    logic             gpio_in = 1'b0;
    logic             pin_out;
    logic [1:0]       pin_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fout_gen #(.CNT_W(CNT_W)) i_fout_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_clk_en(cfg_clk_en),
        .cfg_fo_en(cfg_fo_en), .cfg_sel_cnt(cfg_sel_cnt), .cfg_reload(cfg_reload),
        .gpio_in(gpio_in), .pin_out(pin_out), .pin_src(pin_src)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic ce, input logic fe, input logic sc, input int rl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_clk_en = ce; cfg_fo_en = fe; cfg_sel_cnt = sc;
        cfg_reload = CNT_W'(rl);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int exp_out(input bit sc, input int rl, input int k);
        int p = rl + 1;
        if (k == 0) return 0;
        if (sc) return ((k - 1) % p == 0) ? 1 : 0;
        return (((k - 1) / p) % 2 == 0) ? 1 : 0;
    endfunction

    task automatic step();
        @(posedge clk); #2;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset
        gpio_in = 1'b1;
        #10;
        chk("R1 src in reset", pin_src, 0);
        chk("R1 pin in reset", pin_out, 1);
        #20 rst_n = 1'b1;
        step();
        chk("R1 src after reset", pin_src, 0);
        gpio_in = 1'b0; #1;
        chk("R1 pin follows gpio", pin_out, 0);

        // R2 fields without strobe are ignored
        @(negedge clk);
        cfg_clk_en = 1'b1; cfg_fo_en = 1'b1;
        step(); step();
        chk("R2 no write no change", pin_src, 0);
        cfg_clk_en = 1'b0; cfg_fo_en = 1'b0;

        // R3 R4 R5 R7 vector walk
        foreach (VEC[i]) begin
            bit sc = VEC[i][0];
            int rl = int'(VEC[i][CNT_W:1]);
            wr(1'b0, 1'b0, sc, rl);
            wr(1'b0, 1'b1, sc, rl);
            chk("R7 src freq", pin_src, 1);
            chk(sc ? "R5 k0" : "R4 k0", pin_out, 0);
            for (int k = 1; k <= 2 * (rl + 1) + 3; k++) begin
                step();
                chk(sc ? "R3 R5 strobe" : "R3 R4 toggle", pin_out, exp_out(sc, rl, k));
            end
        end

        // R9 reload change mid-period (strobe mode, 3 -> 1)
        wr(1'b0, 1'b0, 1'b1, 3);
        wr(1'b0, 1'b1, 1'b1, 3);
        step(); chk("R9 k1", pin_out, 1);
        step(); chk("R9 k2", pin_out, 0);
        wr(1'b0, 1'b1, 1'b1, 1);
        for (int k = 4; k <= 10; k++) begin
            step();
            chk("R9 new reload at next underflow", pin_out,
                (k == 5 || k == 7 || k == 9) ? 1 : 0);
        end

        // R8 disable clears latch
        wr(1'b0, 1'b0, 1'b0, 3);
        wr(1'b0, 1'b1, 1'b0, 3);
        step(); chk("R8 latch set", pin_out, 1);
        wr(1'b0, 1'b0, 1'b0, 3);
        gpio_in = 1'b1; #1;
        chk("R7 gpio when disabled", pin_out, 1);
        chk("R7 src gpio", pin_src, 0);
        gpio_in = 1'b0;
        wr(1'b0, 1'b1, 1'b0, 3);
        chk("R8 restart low", pin_out, 0);
        step(); chk("R8 first underflow next clock", pin_out, 1);

        // R6 clock override
        wr(1'b1, 1'b1, 1'b1, 0);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R6 src clk", pin_src, 2);
            chk("R6 pin high phase", pin_out, 1);
            @(negedge clk); #2;
            chk("R6 pin low phase", pin_out, 0);
        end
        wr(1'b0, 1'b1, 1'b1, 0);
        chk("R7 back to freq", pin_src, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule